// File: doc/BRIEF.md
# Parity-Widened Binary Associative Lookup Array

This block is a small binary associative memory. It holds WORDS rows of DW data bits. Each row also keeps a valid flag and one extra check bit. The check bit is the XOR of the row's data bits, so the stored word plus its check bit always holds an even number of ones. Software-side logic fills rows through a write port that is separate from everything else. It then issues either a read, which returns a row by address, or a compare, which presents a key to every row at once.

A compare does several things in the same clock edge. It registers the key's own XOR parity, one match bit per row, the lowest matching row index with a hit flag, and a per-row Hamming distance that includes the check bit. Because the check bit is compared as well, a single flipped data bit always costs two positions. A valid row that is not equal to the key therefore never reports a distance below two. The distance vector exposes this widening so that the effect can be observed directly.

A small controller sequences the outputs. Its state names what the output registers currently present. ST_IDLE shows nothing new. ST_RD_SHOW presents read data for one cycle. ST_CMP_SHOW presents compare results for one cycle. From any state, the op code chooses the next state: OP_READ moves to ST_RD_SHOW, OP_CMP moves to ST_CMP_SHOW, and OP_NONE or OP_RSVD moves to ST_IDLE.

Top module: `parity_cam`

## Requirements
- R1: After reset every row is invalid. A compare with any key, including all zeros, reports no hit, an all-zero match vector and hit_addr 0. rd_valid and res_valid are low until an operation is issued.
- R2: A write stores wr_data and a check bit equal to the XOR of its bits. A read returns both of them on rd_data and rd_parity, with rd_valid high in the cycle after the read is issued and in that cycle only.
- R3: Compare results appear in the cycle after the compare is issued, with res_valid high for exactly that cycle.
- R4: match_vec bit i is 1 exactly when row i is valid and its data equals the key. A matching row reports distance 0.
- R5: For a valid row, the distance is the number of differing data bits plus 1 if the check bits differ. With the default DW=32, one or two differing bits give 2, and three differing bits give 4.
- R6: An invalid row never matches, and its distance field reads all ones. With the default DW=32, each field is 6 bits wide and reads 63.
- R7: When several rows match, hit_addr is the lowest matching index and hit is 1. With no match, hit is 0 and hit_addr is 0.
- R8: A write issued in the same cycle as a compare or a read is not seen by that operation. It is seen by the next one.
- R9: op encodings are 2'b00 none, 2'b01 read, 2'b10 compare and 2'b11 reserved. A none or reserved op raises neither valid output and leaves the result outputs unchanged.
- R10: Every valid row's distance is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Row written |
| wr_data | input | DW | Data written |
| op | input | 2 | Operation code (R9) |
| rd_addr | input | AW | Row read |
| key | input | DW | Compare key |
| rd_valid | output | 1 | Read data presented |
| rd_data | output | DW | Read data |
| rd_parity | output | 1 | Stored check bit of the row read |
| res_valid | output | 1 | Compare results presented |
| key_parity | output | 1 | XOR parity of the last compared key |
| match_vec | output | WORDS | Per-row match bits |
| hit | output | 1 | At least one row matched |
| hit_addr | output | AW | Lowest matching row |
| dist_vec | output | WORDS*CW | Per-row distance, row i in bits [i*CW +: CW] |

## Verification
A stale or corrupted check bit in a row shows up at the next compare with that row's key. The row then reports distance 1 or 3 instead of 0, or it loses its match. A wrong valid flag shows as a distance of 63 where a small number is expected, or the reverse, also on the first compare after the fault. A controller stuck in the wrong state raises the wrong valid strobe, or keeps it high, in the very next cycle.

// File: rtl/pcam_pkg.sv
package pcam_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_READ = 2'b01,
        OP_CMP  = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_RD_SHOW  = 2'b01,
        ST_CMP_SHOW = 2'b10
    } show_state_e;

endpackage

// File: rtl/pcam_row.sv
module pcam_row #(
    parameter int DW = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] key_i,
    input  logic          key_par_i,
    output logic [DW-1:0] data_o,
    output logic          par_o,
    output logic          valid_o,
    output logic          match_o,
    output logic [CW-1:0] dist_o
);

    logic [DW-1:0] data_q;
    logic          par_q;
    logic          valid_q;
    logic [DW-1:0] diff;
    logic [CW-1:0] ones;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            par_q   <= 1'b0;
            valid_q <= 1'b0;
        end else if (we_i) begin
            data_q  <= wdata_i;
            par_q   <= ^wdata_i;
            valid_q <= 1'b1;
        end
    end

    assign diff = data_q ^ key_i;

    always_comb begin
        ones = CW'(par_q ^ key_par_i);
        for (int b = 0; b < DW; b++) begin
            ones = ones + CW'(diff[b]);
        end
    end

    always_comb begin
        if (valid_q) begin
            dist_o  = ones;
            match_o = (ones == '0);
        end else begin
            dist_o  = '1;
            match_o = 1'b0;
        end
    end

    assign data_o  = data_q;
    assign par_o   = par_q;
    assign valid_o = valid_q;

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (par_q == ^data_q)); // R2
    AST_MATCH_ZERO_DIST: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (dist_o == '0) && (data_q == key_i)); // R4
    AST_DIST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (dist_o[0] == 1'b0)); // R10
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> !match_o && (dist_o == '1)); // R6

endmodule

// File: rtl/pcam_prienc.sv
module pcam_prienc #(
    parameter int WORDS = 16,
    parameter int AW    = 4
) (
    input  logic [WORDS-1:0] req_i,
    output logic             any_o,
    output logic [AW-1:0]    idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = AW'(i);
            end
        end
    end

endmodule

// File: rtl/pcam_ctrl.sv
module pcam_ctrl
    import pcam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_i,
    output logic       cap_rd_o,
    output logic       cap_cmp_o,
    output logic       rd_valid_o,
    output logic       res_valid_o
);

    show_state_e state_q, state_d;
    op_e         op;

    assign op = op_e'(op_i);

    always_comb begin
        cap_rd_o  = 1'b0;
        cap_cmp_o = 1'b0;
        unique case (op)
            OP_READ: begin
                state_d  = ST_RD_SHOW;
                cap_rd_o = 1'b1;
            end
            OP_CMP: begin
                state_d   = ST_CMP_SHOW;
                cap_cmp_o = 1'b1;
            end
            OP_NONE, OP_RSVD: state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_valid_o  = 1'b0;
        res_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RD_SHOW:  rd_valid_o  = 1'b1;
            ST_CMP_SHOW: res_valid_o = 1'b1;
            default:     ;
        endcase
    end

    AST_CMP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ($past(op_i) == 2'b10)); // R3
    AST_RD_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ($past(op_i) == 2'b01)); // R2
    AST_SHOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid_o, res_valid_o})); // R9

endmodule

// File: rtl/parity_cam.sv
module parity_cam #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS),
    localparam int CW   = $clog2(DW + 3)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [1:0]          op,
    input  logic [AW-1:0]       rd_addr,
    input  logic [DW-1:0]       key,
    output logic                rd_valid,
    output logic [DW-1:0]       rd_data,
    output logic                rd_parity,
    output logic                res_valid,
    output logic                key_parity,
    output logic [WORDS-1:0]    match_vec,
    output logic                hit,
    output logic [AW-1:0]       hit_addr,
    output logic [WORDS*CW-1:0] dist_vec
);

    logic                cap_rd, cap_cmp;
    logic                key_par;
    logic [DW-1:0]       row_data  [WORDS];
    logic [WORDS-1:0]    row_par;
    logic [WORDS-1:0]    row_valid;
    logic [WORDS-1:0]    row_match;
    logic [WORDS*CW-1:0] row_dist;
    logic                enc_any;
    logic [AW-1:0]       enc_idx;

    assign key_par = ^key;

    pcam_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .cap_rd_o    (cap_rd),
        .cap_cmp_o   (cap_cmp),
        .rd_valid_o  (rd_valid),
        .res_valid_o (res_valid)
    );

    for (genvar i = 0; i < WORDS; i++) begin : g_row
        pcam_row #(.DW(DW), .CW(CW)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_i      (wr_en && (wr_addr == AW'(i))),
            .wdata_i   (wr_data),
            .key_i     (key),
            .key_par_i (key_par),
            .data_o    (row_data[i]),
            .par_o     (row_par[i]),
            .valid_o   (row_valid[i]),
            .match_o   (row_match[i]),
            .dist_o    (row_dist[i*CW +: CW])
        );
    end

    pcam_prienc #(.WORDS(WORDS), .AW(AW)) u_enc (
        .req_i (row_match),
        .any_o (enc_any),
        .idx_o (enc_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rd_parity <= 1'b0;
        end else if (cap_rd) begin
            rd_data   <= row_data[rd_addr];
            rd_parity <= row_par[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_parity <= 1'b0;
            match_vec  <= '0;
            hit        <= 1'b0;
            hit_addr   <= '0;
            dist_vec   <= '0;
        end else if (cap_cmp) begin
            key_parity <= key_par;
            match_vec  <= row_match;
            hit        <= enc_any;
            hit_addr   <= enc_idx;
            dist_vec   <= row_dist;
        end
    end

    AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (hit == (|match_vec))); // R7
    AST_HIT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && hit) |-> match_vec[hit_addr] &&
        ((match_vec & ((WORDS'(1) << hit_addr) - WORDS'(1))) == '0)); // R7
    AST_MISS_ADDR0: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !hit) |-> (hit_addr == '0)); // R7
    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (row_match & ~row_valid) == '0); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cap_cmp) && !res_valid) |-> $stable(match_vec) && $stable(hit_addr)); // R9

endmodule

// File: tb/parity_cam_bench.sv
module parity_cam_bench;

    localparam int WORDS = 16;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int CW    = 6;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                wr_en;
    logic [AW-1:0]       wr_addr;
    logic [DW-1:0]       wr_data;
    logic [1:0]          op;
    logic [AW-1:0]       rd_addr;
    logic [DW-1:0]       key;
    logic                rd_valid, rd_parity, res_valid, key_parity, hit;
    logic [DW-1:0]       rd_data;
    logic [WORDS-1:0]    match_vec;
    logic [AW-1:0]       hit_addr;
    logic [WORDS*CW-1:0] dist_vec;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [DW-1:0] mdl_data [WORDS];
    logic          mdl_val  [WORDS];

    // key, expected hit, expected address
    localparam logic [36:0] VEC [8] = '{
        {32'h1234_5678, 1'b1, 4'd0},
        {32'hDEAD_BEEF, 1'b1, 4'd1},
        {32'h0000_00FF, 1'b1, 4'd3},
        {32'hFFFF_FFFF, 1'b1, 4'd4},
        {32'h8000_0001, 1'b1, 4'd5},
        {32'h0000_0000, 1'b0, 4'd0},
        {32'h1234_5679, 1'b0, 4'd0},
        {32'h0000_00FC, 1'b0, 4'd0}
    };

    parity_cam #(.WORDS(WORDS), .DW(DW)) u_parity_cam (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .op(op), .rd_addr(rd_addr), .key(key),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_parity(rd_parity),
        .res_valid(res_valid), .key_parity(key_parity), .match_vec(match_vec),
        .hit(hit), .hit_addr(hit_addr), .dist_vec(dist_vec)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] mdl_dist(input int r, input logic [DW-1:0] k);
        int n;
        if (!mdl_val[r]) return '1;
        n = $countones(mdl_data[r] ^ k) + ((^mdl_data[r]) != (^k) ? 1 : 0);
        return CW'(n);
    endfunction

    function automatic logic [WORDS*CW-1:0] mdl_dvec(input logic [DW-1:0] k);
        logic [WORDS*CW-1:0] v;
        for (int r = 0; r < WORDS; r++) v[r*CW +: CW] = mdl_dist(r, k);
        return v;
    endfunction

    function automatic logic [WORDS-1:0] mdl_mvec(input logic [DW-1:0] k);
        logic [WORDS-1:0] v;
        for (int r = 0; r < WORDS; r++) v[r] = mdl_val[r] && (mdl_data[r] == k);
        return v;
    endfunction

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl_data[a] = d; mdl_val[a] = 1'b1;
    endtask

    task automatic do_cmp(input logic [DW-1:0] k);
        @(negedge clk);
        op = 2'b10; key = k;
        @(negedge clk);
        op = 2'b00;
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        op = 2'b01; rd_addr = AW'(a);
        @(negedge clk);
        op = 2'b00;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < WORDS; r++) begin mdl_data[r] = '0; mdl_val[r] = 1'b0; end
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        op = 2'b00; rd_addr = '0; key = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_valid", rd_valid, 0);
        check("R1 res_valid", res_valid, 0);
        do_cmp(32'h0);
        check("R3 res_valid", res_valid, 1);
        check("R1 hit", hit, 0);
        check("R1 match_vec", match_vec, 0);
        check("R1 hit_addr", hit_addr, 0);
        check("R6 empty dists", dist_vec, mdl_dvec(32'h0));
        @(negedge clk);
        check("R3 res_valid one cycle", res_valid, 0);

        do_write(0, 32'h1234_5678);
        do_write(1, 32'hDEAD_BEEF);
        do_write(2, 32'h1234_5678);
        do_write(3, 32'h0000_00FF);
        do_write(4, 32'hFFFF_FFFF);
        do_write(5, 32'h8000_0001);

        // R4 R5 R6 R7 table walk
        for (int v = 0; v < 8; v++) begin
            do_cmp(VEC[v][36:5]);
            check("R7 hit", hit, VEC[v][4]);
            check("R7 hit_addr", hit_addr, VEC[v][3:0]);
            check("R4 match_vec", match_vec, mdl_mvec(VEC[v][36:5]));
            check("R5 dist_vec", dist_vec, mdl_dvec(VEC[v][36:5]));
            check("R3 key_parity", key_parity, ^VEC[v][36:5]);
        end

        // R5 distance widening corners
        do_cmp(32'h1234_5679);
        check("R5 one-bit diff", dist_vec[0*CW +: CW], 2);
        do_cmp(32'h0000_00FC);
        check("R5 two-bit diff", dist_vec[3*CW +: CW], 2);
        do_cmp(32'h0000_00F8);
        check("R5 three-bit diff", dist_vec[3*CW +: CW], 4);
        check("R6 invalid row", dist_vec[9*CW +: CW], 63);

        // R2 read
        do_read(1);
        check("R2 rd_valid", rd_valid, 1);
        check("R2 rd_data", rd_data, 32'hDEAD_BEEF);
        check("R2 rd_parity", rd_parity, ^32'hDEAD_BEEF);
        @(negedge clk);
        check("R2 rd_valid one cycle", rd_valid, 0);
        do_read(5);
        check("R2 rd_parity row5", rd_parity, 1'b0);

        // R8 write concurrent with compare
        @(negedge clk);
        op = 2'b10; key = 32'h5555_AAAA;
        wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'h5555_AAAA;
        @(negedge clk);
        op = 2'b00; wr_en = 1'b0;
        check("R8 compare sees old", hit, 0);
        mdl_data[6] = 32'h5555_AAAA; mdl_val[6] = 1'b1;
        do_cmp(32'h5555_AAAA);
        check("R8 next compare sees new", hit_addr, 6);

        // R8 write concurrent with read
        @(negedge clk);
        op = 2'b01; rd_addr = 4'd1;
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h0F0F_0F0E;
        @(negedge clk);
        op = 2'b00; wr_en = 1'b0;
        check("R8 read sees old", rd_data, 32'hDEAD_BEEF);
        mdl_data[1] = 32'h0F0F_0F0E;
        do_read(1);
        check("R8 read sees new", rd_data, 32'h0F0F_0F0E);
        check("R2 new parity", rd_parity, ^32'h0F0F_0F0E);

        // R7 priority moves after overwrite of row 0
        do_write(0, 32'h0000_0001);
        do_cmp(32'h1234_5678);
        check("R7 duplicate lower wins", hit_addr, 2);

        // R9 none and reserved ops
        @(negedge clk);
        op = 2'b11; key = 32'h0000_0001;
        @(negedge clk);
        op = 2'b00;
        check("R9 reserved no valid", {res_valid, rd_valid}, 0);
        check("R9 reserved holds addr", hit_addr, 2);
        @(negedge clk);
        check("R9 none holds match", match_vec, mdl_mvec(32'h1234_5678));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule